// File: doc/BRIEF.md
# Converter Serial Readout Interface

This block models the digital serial side of a sampling converter. It runs in a four-wire mode in which a select line works alongside the convert strobe, and it raises a completion flag before it sends data. The host raises the convert strobe while the select line is high. The block then floats its serial output and counts a fixed number of system clock cycles that stand for the conversion. When the count ends, the block drives the serial output low. A host with a pull-up and an interrupt input can use this edge as the completion flag.

After completion the block holds a copy of the result word, which comes from a test input. The host then clocks the word out with the serial clock, most significant bit first. The block changes the output on each falling serial clock edge, so each bit is steady across the rising edge that follows. The output floats again at the first of two events: the falling edge after the last bit, or a rising edge on the select line. All inputs are sampled in one system clock domain. The block reports tri-state through an enable output and has no bidirectional pin.

Top module: `conv_readout`

## Requirements
- R1: In the idle state the output enable `sdoOutEn` is 1 and `sdoOut` is 0 when `cnvIn` and `sdiIn` are both low. For any other combination, the idle output enable is 0.
- R2: A rising edge on `cnvIn` while `sdiIn` is 1 starts a conversion. From the next clock edge the output enable is 0.
- R3: A rising edge on `cnvIn` while `sdiIn` is 0 does not start a conversion. The block stays idle and undriven, and serial clock edges have no effect.
- R4: Completion comes exactly `CONV_CYCLES` clock edges after the edge that samples the `cnvIn` rise. At completion the output enable becomes 1 with `sdoOut` 0, and this busy flag holds until the first falling `sckIn` edge.
- R5: Changes on `sdiIn` during a conversion are ignored and do not move the completion cycle.
- R6: The k-th falling `sckIn` edge of the readout (k = 1 to `DATA_W`) puts bit `DATA_W-k` of the result word on `sdoOut`. The first edge gives the most significant bit.
- R7: A rising `sckIn` edge during readout leaves `sdoOut` unchanged. A bit stays valid until the next falling edge.
- R8: The falling `sckIn` edge number `DATA_W+1` sets the output enable to 0. It stays 0 until `cnvIn` goes low.
- R9: A rising edge on `sdiIn` during readout sets the output enable to 0. It wins over a falling `sckIn` edge seen in the same cycle.
- R10: `cnvIn` low during a conversion or a readout returns the block to idle at the next clock edge. An aborted conversion never completes.
- R11: The result word is captured at completion. Later changes on `resultIn` do not alter the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cnvIn | input | 1 | Convert strobe |
| sdiIn | input | 1 | Select line |
| sckIn | input | 1 | Serial clock from host |
| resultIn | input | DATA_W | Result word supplied for test |
| sdoOut | output | 1 | Serial data / busy flag value |
| sdoOutEn | output | 1 | Tri-state enable for sdoOut (1 = driven) |

## Verification
Two release causes can fall in the same system clock cycle: a rising edge on the select line and a falling serial clock edge. The bench sets up this collision by raising `sdiIn` in the same interval in which it lowers `sckIn`. It does so once at a mid-word bit, once at the first bit and once at the limit edge. It then requires the output enable to drop after that edge and stay low. The data shift must not win. A second overlap is the convert strobe dropping during readout right after a 1 bit is presented. This must give the idle low drive, not the held data bit.

// File: rtl/conv_readout_pkg.sv
package conv_readout_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2,
    ST_DONE = 2'd3
  } rdState_t;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic loadWord;
    logic sckStep;
  } ctlStrobe_t;

endpackage

// File: rtl/conv_readout_edge.sv
module conv_readout_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] sigIn,
  output logic [W-1:0] riseOut,
  output logic [W-1:0] fallOut
);
  logic [W-1:0] prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= sigIn;
  end

  for (genvar i = 0; i < W; i++) begin : g_edge
    assign riseOut[i] = sigIn[i] & ~prevQ[i];
    assign fallOut[i] = ~sigIn[i] & prevQ[i];
  end
endmodule

// File: rtl/conv_readout_ctrl.sv
module conv_readout_ctrl
  import conv_readout_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cnvIn,
  input  logic       sdiIn,
  input  logic       cnvRise,
  input  logic       sdiRise,
  input  logic       sckFall,
  input  logic       convDone,
  input  logic       lastFall,
  output rdState_t   stateQ,
  output ctlStrobe_t strobe
);
  rdState_t stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (cnvRise && sdiIn) begin
          stateD        = ST_CONV;
          strobe.clrCnt = 1'b1;
        end
      end
      ST_CONV: begin
        if (!cnvIn) begin
          stateD = ST_IDLE;
        end else if (convDone) begin
          stateD          = ST_READ;
          strobe.loadWord = 1'b1;
        end else begin
          strobe.incCnt = 1'b1;
        end
      end
      ST_READ: begin
        if (!cnvIn) begin
          stateD = ST_IDLE;
        end else if (sdiRise) begin
          stateD = ST_DONE;
        end else if (sckFall) begin
          if (lastFall) stateD = ST_DONE;
          else          strobe.sckStep = 1'b1;
        end
      end
      ST_DONE: begin
        if (!cnvIn) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end
endmodule

// File: rtl/conv_readout_dpath.sv
module conv_readout_dpath
  import conv_readout_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int CONV_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] resultIn,
  output logic              convDone,
  output logic              lastFall,
  output logic              dataPhase,
  output logic              dataBit,
  output logic [$clog2(CONV_CYCLES)-1:0] convCnt
);
  localparam int CNT_W  = $clog2(CONV_CYCLES);
  localparam int FALL_W = $clog2(DATA_W + 2);

  logic [DATA_W-1:0] shiftQ;
  logic [FALL_W-1:0] fallCnt;

  always_ff @(posedge clk) begin
    if (!rstN)              convCnt <= '0;
    else if (strobe.clrCnt) convCnt <= '0;
    else if (strobe.incCnt) convCnt <= convCnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ  <= '0;
      fallCnt <= '0;
    end else if (strobe.loadWord) begin
      shiftQ  <= resultIn;
      fallCnt <= '0;
    end else if (strobe.sckStep) begin
      fallCnt <= fallCnt + FALL_W'(1);
      if (fallCnt != '0) shiftQ <= {shiftQ[DATA_W-2:0], 1'b0};
    end
  end

  assign convDone  = (convCnt == CNT_W'(CONV_CYCLES - 1));
  assign lastFall  = (fallCnt == FALL_W'(DATA_W));
  assign dataPhase = (fallCnt != '0);
  assign dataBit   = shiftQ[DATA_W-1];
endmodule

// File: rtl/conv_readout.sv
module conv_readout
  import conv_readout_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int CONV_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cnvIn,
  input  logic              sdiIn,
  input  logic              sckIn,
  input  logic [DATA_W-1:0] resultIn,
  output logic              sdoOut,
  output logic              sdoOutEn
);
  localparam int CNT_W = $clog2(CONV_CYCLES);

  logic [2:0]       riseVec;
  logic [2:0]       fallVec;
  logic             cnvRise;
  logic             sdiRise;
  logic             sckFall;
  logic             convDone;
  logic             lastFall;
  logic             dataPhase;
  logic             dataBit;
  logic [CNT_W-1:0] convCnt;
  rdState_t         ctlState;
  ctlStrobe_t       strobe;

  conv_readout_edge #(.W(3)) u_edge (
    .clk     (clk),
    .rstN    (rstN),
    .sigIn   ({sckIn, sdiIn, cnvIn}),
    .riseOut (riseVec),
    .fallOut (fallVec)
  );

  assign cnvRise = riseVec[0];
  assign sdiRise = riseVec[1];
  assign sckFall = fallVec[2];

  conv_readout_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cnvIn    (cnvIn),
    .sdiIn    (sdiIn),
    .cnvRise  (cnvRise),
    .sdiRise  (sdiRise),
    .sckFall  (sckFall),
    .convDone (convDone),
    .lastFall (lastFall),
    .stateQ   (ctlState),
    .strobe   (strobe)
  );

  conv_readout_dpath #(
    .DATA_W      (DATA_W),
    .CONV_CYCLES (CONV_CYCLES)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .resultIn  (resultIn),
    .convDone  (convDone),
    .lastFall  (lastFall),
    .dataPhase (dataPhase),
    .dataBit   (dataBit),
    .convCnt   (convCnt)
  );

  always_comb begin
    sdoOutEn = 1'b0;
    sdoOut   = 1'b0;
    if (ctlState == ST_READ) begin
      sdoOutEn = 1'b1;
      sdoOut   = dataPhase & dataBit;
    end else if (ctlState == ST_IDLE && !cnvIn && !sdiIn) begin
      sdoOutEn = 1'b1;
    end
  end
endmodule

// File: rtl/conv_readout_chk.sv
module conv_readout_chk
  import conv_readout_pkg::*;
#(
  parameter int CONV_CYCLES = 40
) (
  input logic     clk,
  input logic     rstN,
  input logic     cnvIn,
  input logic     sdiIn,
  input logic     cnvRise,
  input logic     sdiRise,
  input logic     sckFall,
  input logic     sdoOut,
  input logic     sdoOutEn,
  input rdState_t ctlState,
  input logic [$clog2(CONV_CYCLES)-1:0] convCnt
);
  // R2
  start_floats_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == ST_IDLE && cnvRise && sdiIn) |=> !sdoOutEn);

  // R3
  no_start_low_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == ST_IDLE && cnvRise && !sdiIn) |=> (ctlState == ST_IDLE));

  // R4
  conv_count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == ST_CONV) |-> (convCnt < CONV_CYCLES));

  // R7
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == ST_READ && cnvIn && !sckFall && !sdiRise) |=> $stable(sdoOut) && sdoOutEn);

  // R8
  done_floats_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == ST_DONE) |-> !sdoOutEn);

  // R9
  sel_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == ST_READ && cnvIn && sdiRise) |=> (ctlState == ST_DONE));

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState != ST_IDLE && !cnvIn) |=> (ctlState == ST_IDLE));
endmodule

bind conv_readout conv_readout_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cnvIn    (cnvIn),
  .sdiIn    (sdiIn),
  .cnvRise  (cnvRise),
  .sdiRise  (sdiRise),
  .sckFall  (sckFall),
  .sdoOut   (sdoOut),
  .sdoOutEn (sdoOutEn),
  .ctlState (ctlState),
  .convCnt  (convCnt)
);

// File: tb/conv_readout_bench.sv
`timescale 1ns/1ps
module conv_readout_bench;
  localparam int DATA_W = 14;
  localparam int C      = 24;
  localparam int NV     = 6;
  // {changeResult, releaseAtFall[4:0], word[13:0]}
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 5'd0,  14'h2A5C},
    {1'b1, 5'd0,  14'h3FFF},
    {1'b0, 5'd0,  14'h0001},
    {1'b0, 5'd5,  14'h1234},
    {1'b1, 5'd15, 14'h2000},
    {1'b0, 5'd1,  14'h1555}
  };

  logic clk = 1'b0;
  logic rstN, cnvIn, sdiIn, sckIn;
  logic [DATA_W-1:0] resultIn;
  logic sdoOut, sdoOutEn;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  conv_readout #(.DATA_W(DATA_W), .CONV_CYCLES(C)) u_conv_readout (
    .clk(clk), .rstN(rstN), .cnvIn(cnvIn), .sdiIn(sdiIn), .sckIn(sckIn),
    .resultIn(resultIn), .sdoOut(sdoOut), .sdoOutEn(sdoOutEn)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic expEn, input logic expSdo, input bit careSdo);
    checks++;
    if (sdoOutEn !== expEn || (careSdo && expEn && sdoOut !== expSdo)) begin
      errors++;
      $display("FAIL %s: en=%b sdo=%b expected en=%b sdo=%b", req, sdoOutEn, sdoOut, expEn, expSdo);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: en=%b sdo=%b expected run end", sdoOutEn, sdoOut);
    finish_run();
  end

  initial begin
    logic [DATA_W-1:0] word;
    int rel;
    bit chg;
    bit released;
    rstN = 1'b0; cnvIn = 1'b0; sdiIn = 1'b0; sckIn = 1'b0; resultIn = '0;
    step(3);
    check("R1 reset idle drive", 1'b1, 1'b0, 1'b1);
    rstN = 1'b1;
    sdiIn = 1'b1; #1;
    check("R1 idle sel high floats", 1'b0, 1'b0, 1'b0);
    step(1);

    for (int v = 0; v < NV; v++) begin
      word = VEC[v][13:0]; rel = int'(VEC[v][18:14]); chg = VEC[v][19];
      resultIn = word; sdiIn = 1'b1; cnvIn = 1'b1;
      step(1);
      check("R2 conversion floats", 1'b0, 1'b0, 1'b0);
      sdiIn = 1'b0; step(2);
      sdiIn = 1'b1; step(2);
      sdiIn = 1'b0; step(C - 5);
      check("R5 R4 still converting", 1'b0, 1'b0, 1'b0);
      step(1);
      check("R4 busy flag low", 1'b1, 1'b0, 1'b1);
      if (chg) resultIn = ~word;
      released = 1'b0;
      for (int k = 1; k <= DATA_W + 1; k++) begin
        sckIn = 1'b1; step(1);
        if (!released)
          check(chg ? "R11 R7 hold on rise" : "R7 hold on rise", 1'b1,
                (k == 1) ? 1'b0 : word[DATA_W - k + 1], 1'b1);
        sckIn = 1'b0;
        if (rel == k) sdiIn = 1'b1;
        step(1);
        if (rel == k) begin
          check("R9 select release", 1'b0, 1'b0, 1'b0);
          released = 1'b1;
        end else if (released) begin
          check("R9 stays released", 1'b0, 1'b0, 1'b0);
        end else if (k <= DATA_W) begin
          check(chg ? "R11 R6 data bit" : "R6 data bit", 1'b1, word[DATA_W - k], 1'b1);
        end else begin
          check("R8 limit release", 1'b0, 1'b0, 1'b0);
        end
      end
      sckIn = 1'b1; step(1); sckIn = 1'b0; step(1);
      check("R8 R9 no drive after release", 1'b0, 1'b0, 1'b0);
      cnvIn = 1'b0; sdiIn = 1'b0; step(1);
      check("R1 back to idle drive", 1'b1, 1'b0, 1'b1);
      step(2);
    end

    // R3: rise with select low
    sdiIn = 1'b0; cnvIn = 1'b1; step(C + 3);
    check("R3 no conversion", 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      sckIn = 1'b1; step(1); sckIn = 1'b0; step(1);
    end
    check("R3 sck ignored", 1'b0, 1'b0, 1'b0);
    cnvIn = 1'b0; step(1);
    check("R3 R1 idle drive", 1'b1, 1'b0, 1'b1);

    // R10: abort a conversion, then restart
    resultIn = 14'h3FFF;
    sdiIn = 1'b1; cnvIn = 1'b1; step(1);
    sdiIn = 1'b0; step(5);
    cnvIn = 1'b0; step(1);
    check("R10 abort conversion", 1'b1, 1'b0, 1'b1);
    sdiIn = 1'b1; cnvIn = 1'b1; step(1);
    sdiIn = 1'b0; step(C - 1);
    check("R10 R4 fresh count", 1'b0, 1'b0, 1'b0);
    step(1);
    check("R10 R4 completion", 1'b1, 1'b0, 1'b1);
    // R10: abort readout after a 1 bit
    sckIn = 1'b1; step(1); sckIn = 1'b0; step(1);
    check("R6 msb before abort", 1'b1, 1'b1, 1'b1);
    cnvIn = 1'b0; step(1);
    check("R10 abort readout", 1'b1, 1'b0, 1'b1);
    step(2);
    finish_run();
  end
endmodule